// File: doc/BRIEF.md
# UTOPIA Level 2 Transmit-Side PHY Port

This block sits on the PHY side of a shared multi-PHY cell bus. It handles the ATM-to-PHY direction. The ATM-layer master polls the ports by driving a 5-bit address. This port answers only when the address is its own. It then drives its cell-available line, together with an output-enable for the shared tri-state wire, on the following clock. The value it drives says whether the downstream cell buffer has room for a whole cell.

To send a cell, the master first presents the port's address while the active-low enable is high. It then pulls the enable low and drives the first byte with start-of-cell. One byte moves per clock while the enable stays low. The master may pause at any time by raising the enable. Each accepted byte goes out on a buffer write interface with its byte index, and the 53rd byte is marked as the end of the cell. A start-of-cell that arrives in the middle of a cell abandons the partial cell: the block pulses a drop strobe and restarts the count. Every written byte is checked for odd parity. A mismatch sets a sticky error flag, and the byte is still written.

Top module: `utopia_tx_port`

## Requirements
- R1: While reset is active and on the first cycle after it, `clav_oe`, `clav`, `wr_en`, `wr_last`, `wr_drop` and `par_err` are 0.
- R2: `clav_oe` is 1 in the cycle after a clock edge at which `tx_addr` equals `own_addr`, and 0 after an edge at which it does not.
- R3: When `clav_oe` is 1, `clav` equals the value `buf_room` had at the same clock edge.
- R4: A byte is written only at an edge where `tx_enb` is 0 and the port is selected. While `tx_enb` is 1 (a pause), nothing is written and the cell position is kept.
- R5: The port becomes selected at an edge where `tx_enb` is 1 and `tx_addr` equals `own_addr`. It becomes deselected at an edge where `tx_enb` is 1 and `tx_addr` differs.
- R6: A byte accepted with `tx_soc` = 1 is written with `wr_idx` = 0. Each following accepted byte of the cell is written with the next index, up to 52.
- R7: The byte written with `wr_idx` = 52 carries `wr_last` = 1 and ends the cell. Accepted bytes without `tx_soc` outside a cell are not written.
- R8: A byte with `tx_soc` = 1 accepted while a cell is in progress pulses `wr_drop` with its own write, which has index 0.
- R9: Odd parity applies: `tx_par` must make the total count of ones in {`tx_data`, `tx_par`} odd, so 0x00 needs parity 1. A written byte that breaks this sets `par_err`. The flag stays set until reset, and the byte is still written.
- R10: The write outputs (`wr_en`, `wr_data`, `wr_idx`, `wr_last`, `wr_drop`) appear in the cycle after the edge that accepted the byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 5 | Programmed address of this port |
| buf_room | input | 1 | Downstream buffer can take a complete cell |
| tx_data | input | 8 | Cell byte from the master |
| tx_par | input | 1 | Odd parity bit for tx_data |
| tx_soc | input | 1 | Start-of-cell marker on the first byte |
| tx_addr | input | 5 | Poll / select address from the master |
| tx_enb | input | 1 | Active-low transfer enable |
| clav | output | 1 | Cell-available value for the shared line |
| clav_oe | output | 1 | Output-enable for the shared cell-available line |
| wr_en | output | 1 | Buffer write strobe |
| wr_data | output | 8 | Byte to store |
| wr_idx | output | 6 | Byte position within the cell (0..52) |
| wr_last | output | 1 | Final byte of a complete cell |
| wr_drop | output | 1 | Partial cell abandoned; this write restarts a cell |
| par_err | output | 1 | Sticky parity error flag |

## Verification
The bench polls the port's own address and a foreign one with the buffer both full and free. A port that drove the shared line for every address, or reported a stale room value, fails these checks. A whole cell is sent with a pause in the middle, followed by a stray byte with no start-of-cell. A design that wrote during the pause, lost its position or stored the orphan byte produces a write the scoreboard does not expect. A start-of-cell is injected ten bytes into a cell, and a transfer is attempted after the master has moved to another address. These catch a design that carried the old count on, omitted the drop pulse, or kept listening after deselection. One byte with flipped parity checks that the flag latches while the byte is still stored.

// File: rtl/utopia_tx_pkg.sv
package utopia_tx_pkg;

  typedef enum logic [0:0] {
    ASM_IDLE = 1'b0,
    ASM_FILL = 1'b1
  } asm_state_t;

  // True when the byte plus its parity bit hold an odd count of ones.
  function automatic logic odd_ok(input logic [7:0] d, input logic p);
    return ^{d, p};
  endfunction

endpackage

// File: rtl/utx_poll.sv
module utx_poll #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] tx_addr,
  input  logic              buf_room,
  output logic              clav,
  output logic              clav_oe
);

  logic hit;
  logic clav_d, oe_d;

  always_comb begin
    hit    = (tx_addr == own_addr);
    oe_d   = hit;
    clav_d = hit & buf_room;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clav    <= 1'b0;
      clav_oe <= 1'b0;
    end else begin
      clav    <= clav_d;
      clav_oe <= oe_d;
    end
  end

endmodule

// File: rtl/utx_select.sv
module utx_select #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] tx_addr,
  input  logic              tx_enb,
  output logic              accept
);

  logic sel_q, sel_d;

  always_comb begin
    sel_d = sel_q;
    if (tx_enb) begin
      sel_d = (tx_addr == own_addr);
    end
    accept = sel_q & ~tx_enb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
    end
  end

endmodule

// File: rtl/utx_parity.sv
module utx_parity #(
  parameter int DATA_W    = 8,
  parameter bit PAR_CHECK = 1'b1
) (
  input  logic [DATA_W-1:0] data,
  input  logic              par,
  output logic              bad
);

  generate
    if (PAR_CHECK) begin : g_check
      always_comb bad = ~(^{data, par});
    end else begin : g_nocheck
      always_comb bad = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/utx_assembler.sv
module utx_assembler
  import utopia_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53,
  localparam int IDX_W     = $clog2(CELL_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              soc,
  input  logic [DATA_W-1:0] data,
  input  logic              bad,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic [IDX_W-1:0]  wr_idx,
  output logic              wr_last,
  output logic              wr_drop,
  output logic              par_err
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

  asm_state_t        state_q, state_d;
  logic [IDX_W-1:0]  cnt_q, cnt_d;
  logic              wen_d, last_d, drop_d, err_d;
  logic [IDX_W-1:0]  idx_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wen_d   = 1'b0;
    last_d  = 1'b0;
    drop_d  = 1'b0;
    idx_d   = wr_idx;
    data_d  = wr_data;
    if (accept) begin
      if (soc) begin
        wen_d   = 1'b1;
        drop_d  = (state_q == ASM_FILL);
        idx_d   = '0;
        data_d  = data;
        if (LAST_IDX == '0) begin
          last_d  = 1'b1;
          state_d = ASM_IDLE;
          cnt_d   = '0;
        end else begin
          state_d = ASM_FILL;
          cnt_d   = IDX_W'(1);
        end
      end else if (state_q == ASM_FILL) begin
        wen_d  = 1'b1;
        idx_d  = cnt_q;
        data_d = data;
        if (cnt_q == LAST_IDX) begin
          last_d  = 1'b1;
          state_d = ASM_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + IDX_W'(1);
        end
      end
    end
    err_d = par_err | (wen_d & bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ASM_IDLE;
      cnt_q   <= '0;
      wr_en   <= 1'b0;
      wr_last <= 1'b0;
      wr_drop <= 1'b0;
      par_err <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wr_en   <= wen_d;
      wr_last <= last_d;
      wr_drop <= drop_d;
      par_err <= err_d;
      if (wen_d) begin
        wr_idx  <= idx_d;
        wr_data <= data_d;
      end
    end
  end

endmodule

// File: rtl/utopia_tx_port.sv
module utopia_tx_port #(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53,
  parameter bit PAR_CHECK  = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             own_addr,
  input  logic                          buf_room,
  input  logic [DATA_W-1:0]             tx_data,
  input  logic                          tx_par,
  input  logic                          tx_soc,
  input  logic [ADDR_W-1:0]             tx_addr,
  input  logic                          tx_enb,
  output logic                          clav,
  output logic                          clav_oe,
  output logic                          wr_en,
  output logic [DATA_W-1:0]             wr_data,
  output logic [$clog2(CELL_BYTES)-1:0] wr_idx,
  output logic                          wr_last,
  output logic                          wr_drop,
  output logic                          par_err
);

  logic accept;
  logic bad;

  utx_poll #(.ADDR_W(ADDR_W)) u_poll (
    .clk      (clk),
    .rst_n    (rst_n),
    .own_addr (own_addr),
    .tx_addr  (tx_addr),
    .buf_room (buf_room),
    .clav     (clav),
    .clav_oe  (clav_oe)
  );

  utx_select #(.ADDR_W(ADDR_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .own_addr (own_addr),
    .tx_addr  (tx_addr),
    .tx_enb   (tx_enb),
    .accept   (accept)
  );

  utx_parity #(.DATA_W(DATA_W), .PAR_CHECK(PAR_CHECK)) u_par (
    .data (tx_data),
    .par  (tx_par),
    .bad  (bad)
  );

  utx_assembler #(.DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES)) u_asm (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .soc     (tx_soc),
    .data    (tx_data),
    .bad     (bad),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wr_idx  (wr_idx),
    .wr_last (wr_last),
    .wr_drop (wr_drop),
    .par_err (par_err)
  );

endmodule

// File: rtl/utopia_tx_port_chk.sv
module utopia_tx_port_chk #(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [ADDR_W-1:0]             own_addr,
  input logic                          buf_room,
  input logic [ADDR_W-1:0]             tx_addr,
  input logic                          tx_enb,
  input logic                          clav,
  input logic                          clav_oe,
  input logic                          wr_en,
  input logic [$clog2(CELL_BYTES)-1:0] wr_idx,
  input logic                          wr_last,
  input logic                          wr_drop,
  input logic                          par_err
);

  p_oe_addressed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clav_oe |-> ($past(tx_addr) == $past(own_addr)));

  p_clav_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clav_oe |-> (clav == $past(buf_room)));

  p_write_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$past(tx_enb));

  p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < CELL_BYTES));

  p_last_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last |-> (wr_en && int'(wr_idx) == CELL_BYTES - 1));

  p_drop_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |-> (wr_en && wr_idx == '0));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(par_err) |-> par_err);

endmodule

bind utopia_tx_port utopia_tx_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .buf_room(buf_room),
  .tx_addr(tx_addr), .tx_enb(tx_enb), .clav(clav), .clav_oe(clav_oe),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_last(wr_last), .wr_drop(wr_drop),
  .par_err(par_err)
);

// File: tb/utopia_tx_port_test.sv
module utopia_tx_port_test;

  localparam int PERIOD = 10;
  localparam logic [4:0] OWN   = 5'd9;
  localparam logic [4:0] OTHER = 5'd3;

  logic       clk;
  logic       rst_n;
  logic [4:0] own_addr;
  logic       buf_room;
  logic [7:0] tx_data;
  logic       tx_par;
  logic       tx_soc;
  logic [4:0] tx_addr;
  logic       tx_enb;
  logic       clav, clav_oe, wr_en, wr_last, wr_drop, par_err;
  logic [7:0] wr_data;
  logic [5:0] wr_idx;

  int checks = 0;
  int fails  = 0;
  int drops_seen = 0;
  int drops_exp  = 0;
  int exp_idx    = 0;
  bit in_cell    = 0;
  bit done_flag  = 0;
  logic [14:0] exp_q[$];

  utopia_tx_port uut (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .buf_room(buf_room),
    .tx_data(tx_data), .tx_par(tx_par), .tx_soc(tx_soc), .tx_addr(tx_addr),
    .tx_enb(tx_enb), .clav(clav), .clav_oe(clav_oe), .wr_en(wr_en),
    .wr_data(wr_data), .wr_idx(wr_idx), .wr_last(wr_last),
    .wr_drop(wr_drop), .par_err(par_err)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4/R7 unexpected write", int'(wr_idx), -1);
      end else begin
        logic [14:0] e;
        e = exp_q.pop_front();
        chk(wr_data == e[7:0], "R6 data", wr_data, e[7:0]);
        chk(wr_idx == e[13:8], "R6 index", wr_idx, e[13:8]);
        chk(wr_last == e[14], "R7 last", wr_last, e[14]);
      end
    end
    if (rst_n && wr_drop) drops_seen++;
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic poll(input logic [4:0] a, input logic room);
    tx_enb = 1'b1; tx_addr = a; buf_room = room;
    tick();
    chk(clav_oe == (a == OWN), "R2 clav_oe", clav_oe, a == OWN);
    if (a == OWN) chk(clav == room, "R3 clav value", clav, room);
  endtask

  task automatic select_addr(input logic [4:0] a);
    tx_enb = 1'b1; tx_addr = a;
    tick();
  endtask

  task automatic send(input logic [7:0] d, input bit soc, input bit flip_par);
    bit will_write;
    tx_enb = 1'b0; tx_data = d; tx_soc = soc;
    tx_par = (~^d) ^ flip_par;
    will_write = soc || in_cell;
    if (soc) begin
      if (in_cell) drops_exp++;
      exp_idx = 0;
      in_cell = 1;
    end
    if (will_write) begin
      exp_q.push_back({exp_idx == 52, 6'(exp_idx), d});
      if (exp_idx == 52) in_cell = 0;
      exp_idx++;
    end
    tick();
    tx_soc = 1'b0;
  endtask

  task automatic pause(input int n);
    for (int i = 0; i < n; i++) begin
      tx_enb = 1'b1; tx_addr = OWN; tx_data = 8'hEE;
      tick();
      chk(wr_en == 1'b0, "R4 pause no write", wr_en, 0);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    rst_n = 1'b0; own_addr = OWN; buf_room = 1'b0; tx_data = '0;
    tx_par = 1'b1; tx_soc = 1'b0; tx_addr = 5'd0; tx_enb = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(clav_oe == 0 && clav == 0, "R1 reset clav", clav_oe, 0);
    chk(wr_en == 0 && wr_last == 0 && wr_drop == 0, "R1 reset write", wr_en, 0);
    chk(par_err == 0, "R1 reset par_err", par_err, 0);
    rst_n = 1'b1;
    tick();
    chk(clav_oe == 0 && wr_en == 0 && par_err == 0, "R1 after release", clav_oe, 0);

    // R2/R3 polling
    poll(OWN, 1'b1);
    poll(OWN, 1'b0);
    poll(OTHER, 1'b1);
    poll(OWN, 1'b1);

    // Full cell with a pause (R5, R6, R7, R10); byte 0x00 exercises R9 parity 1
    select_addr(OWN);
    send(8'h00, 1, 0);
    chk(wr_en == 1 && wr_idx == 0, "R10 write one cycle later", wr_en, 1);
    for (int i = 1; i < 20; i++) send(8'(i * 7), 0, 0);
    pause(2);
    for (int i = 20; i < 53; i++) send(8'(i * 7 + 1), 0, 0);
    // R7 orphan byte without start-of-cell
    send(8'hA5, 0, 0);
    chk(wr_en == 0, "R7 orphan byte ignored", wr_en, 0);
    chk(par_err == 0, "R9 good parity keeps flag clear", par_err, 0);

    // R8 mid-cell restart
    pause(1);
    send(8'h11, 1, 0);
    for (int i = 1; i < 10; i++) send(8'(8'h20 + i), 0, 0);
    send(8'h33, 1, 0);
    chk(wr_drop == 1 && wr_idx == 0, "R8 drop pulse", wr_drop, 1);
    for (int i = 1; i < 53; i++) send(8'(8'h40 + i), 0, 0);

    // R5 deselection: another address with enable high, then transfer
    select_addr(OTHER);
    tx_enb = 1'b0; tx_soc = 1'b1; tx_data = 8'h5A; tx_par = ~^8'h5A;
    tick();
    tx_soc = 1'b0;
    tick();
    chk(wr_en == 0, "R5 deselected no write", wr_en, 0);

    // R9 parity error on a written byte
    select_addr(OWN);
    send(8'h81, 1, 0);
    send(8'h7E, 0, 1);
    chk(par_err == 1, "R9 error set", par_err, 1);
    for (int i = 2; i < 53; i++) send(8'(i), 0, 0);
    chk(par_err == 1, "R9 error sticky", par_err, 1);
    pause(3);

    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
    chk(drops_seen == drops_exp, "R8 drop count", drops_seen, drops_exp);
    done_flag = 1;
    report();
  end

endmodule